// File: doc/BRIEF.md
# Receive Interrupt Coalescing Unit

This unit sits between a network receive path and the interrupt controller. It watches a per-frame "frame received" strobe. Each strobe carries a flag that says whether that frame asks for an interrupt. The unit holds back the receive interrupt so that software is not interrupted once per frame. The interrupt is released as soon as a programmed number of flagged frames has arrived, or when a programmed time has passed since the first flagged frame of the current batch, whichever happens first. Either release starts a new batch.

The wait time is counted in units of 64 events of a selectable source. The source is either the system clock or the rising edges of the receive-interface clock. That interface clock is brought into the system clock domain through a two-stage synchronizer and an edge detector. With coalescing switched off, every flagged frame raises the interrupt at once. The raised interrupt is a sticky pending flag. It stays set until software acknowledges it, and a mask input gates it at the output.

Top module: `rx_irq_coalescer`

## Requirements
- R1: During and after synchronous reset, `irq_out` is low, no interrupt is pending, the batch count is zero and the wait timer is idle.
- R2: With `cfg_enable` low, a flagged frame (`frm_valid` and `frm_irq_flag` both high) sampled at clock edge k makes `irq_out` high after edge k, when unmasked.
- R3: A frame with `frm_irq_flag` low is neither counted nor allowed to start the wait timer, in either mode.
- R4: With `cfg_enable` high, the interrupt is raised at the edge that samples the `cfg_frame_thresh`-th flagged frame since the last release or since enabling.
- R5: With `cfg_enable` high and `cfg_tmr_sel` = 1, a flagged frame sampled at edge a while the timer is idle starts the timer. If no frame release happens first, the interrupt is raised at edge a + 64 × `cfg_timer_thresh`.
- R6: Flagged frames arriving while the timer runs do not restart it. After any release the timer stays idle until the next flagged frame.
- R7: With `cfg_tmr_sel` = 0, the timer advances only on synchronized rising edges of `ifc_clk`, and system clock cycles alone never advance it. With `cfg_tmr_sel` = 1, it advances on every system clock.
- R8: When the frame threshold and the timer expiry fall on the same edge, exactly one interrupt results.
- R9: Once raised, the pending interrupt stays high until an `sw_ack` cycle clears it at the next edge. A release sampled in the same cycle as `sw_ack` wins, and the interrupt stays pending.
- R10: Flagged frames keep being counted while an interrupt is pending, so a later batch can complete before or after the acknowledge.
- R11: `irq_out` is the registered AND of the pending state with `irq_unmask`. While masked, the pending state is kept, and it appears on `irq_out` one edge after `irq_unmask` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ifc_clk | input | 1 | Receive-interface clock, asynchronous, sampled for rising edges |
| frm_valid | input | 1 | One-cycle strobe per received frame |
| frm_irq_flag | input | 1 | Frame requests an interrupt, qualifies `frm_valid` |
| cfg_enable | input | 1 | 1 = coalesce, 0 = interrupt on every flagged frame |
| cfg_tmr_sel | input | 1 | Timer source: 0 = interface clock edges, 1 = system clock |
| cfg_frame_thresh | input | 8 | Frames per batch, nonzero |
| cfg_timer_thresh | input | 16 | Wait time in units of 64 source events, nonzero |
| irq_unmask | input | 1 | 1 = receive interrupt allowed onto the output |
| sw_ack | input | 1 | Software acknowledge, clears the pending interrupt |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The assertions assume that both thresholds are nonzero and that the configuration fields change only while `cfg_enable` is low. The count-bound property relies on this: the batch count stays below the frame threshold. They also assume `frm_valid` is a clean synchronous strobe. The bench keeps to these assumptions. Every reconfiguration first drops `cfg_enable` for a cycle, then writes the new thresholds and select together with the enable. All frame strobes are driven on the falling clock edge, one cycle wide. The interface clock is driven only as a slow free-running square wave, so the synchronizer never sees a pulse shorter than two system cycles.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  localparam int unsigned PRESC_DIV_DEF = 64;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef enum logic {
    TMR_IDLE = 1'b0,
    TMR_RUN  = 1'b1
  } tmr_state_e;
endpackage

// File: rtl/rxc_edge_sync.sv
module rxc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_pulse
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_in};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_pulse = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/rxc_prescaler.sv
module rxc_prescaler #(
  parameter int unsigned DIV = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic src_evt,
  output logic step
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (src_evt) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign step = run & src_evt & (cnt_q == LAST);
endmodule

// File: rtl/rxc_frame_counter.sv
module rxc_frame_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] thresh,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_plus;

  assign cnt_plus = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (inc) begin
      cnt_q <= cnt_plus[CNT_W-1:0];
    end
  end

  assign hit = inc & (cnt_plus == {1'b0, thresh});
  assign cnt = cnt_q;
endmodule

// File: rtl/rxc_wait_timer.sv
module rxc_wait_timer
  import rxc_pkg::*;
#(
  parameter int unsigned TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             stop,
  input  logic             step,
  input  logic [TMR_W-1:0] thresh,
  output logic             running,
  output logic             expire
);
  tmr_state_e       state_q;
  logic [TMR_W-1:0] val_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TMR_IDLE;
      val_q   <= '0;
    end else if (stop) begin
      state_q <= TMR_IDLE;
    end else if (arm) begin
      state_q <= TMR_RUN;
      val_q   <= thresh;
    end else if (state_q == TMR_RUN && step) begin
      val_q <= val_q - 1'b1;
    end
  end

  assign running = (state_q == TMR_RUN);
  assign expire  = running & step & (val_q == TMR_W'(1));
endmodule

// File: rtl/rx_irq_coalescer.sv
module rx_irq_coalescer
  import rxc_pkg::*;
#(
  parameter int unsigned FCNT_W      = 8,
  parameter int unsigned TMR_W       = 16,
  parameter int unsigned PRESC_DIV   = PRESC_DIV_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ifc_clk,
  input  logic              frm_valid,
  input  logic              frm_irq_flag,
  input  logic              cfg_enable,
  input  logic              cfg_tmr_sel,
  input  logic [FCNT_W-1:0] cfg_frame_thresh,
  input  logic [TMR_W-1:0]  cfg_timer_thresh,
  input  logic              irq_unmask,
  input  logic              sw_ack,
  output logic              irq_out
);
  logic              qual;
  logic              ifc_rise;
  logic              src_evt;
  logic              tmr_step;
  logic              tmr_running;
  logic              tmr_exp;
  logic              tmr_arm;
  logic              tmr_stop;
  logic              cnt_hit;
  logic [FCNT_W-1:0] cnt_q;
  logic              fire_c;
  logic              pend_q;
  logic              pend_n;
  logic              irq_q;

  assign qual = frm_valid & frm_irq_flag;

  rxc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .async_in   (ifc_clk),
    .rise_pulse (ifc_rise)
  );

  assign src_evt = cfg_tmr_sel ? 1'b1 : ifc_rise;

  rxc_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .run     (tmr_running),
    .src_evt (src_evt),
    .step    (tmr_step)
  );

  rxc_frame_counter #(.CNT_W(FCNT_W)) u_fcnt (
    .clk    (clk),
    .rst    (rst),
    .clr    (fire_c | ~cfg_enable),
    .inc    (qual & cfg_enable),
    .thresh (cfg_frame_thresh),
    .cnt    (cnt_q),
    .hit    (cnt_hit)
  );

  // one release per cycle, whichever condition (or both) occurred
  assign fire_c   = cfg_enable ? (cnt_hit | tmr_exp) : qual;
  assign tmr_stop = fire_c | ~cfg_enable;
  assign tmr_arm  = cfg_enable & qual & ~tmr_running & ~fire_c;

  rxc_wait_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .arm     (tmr_arm),
    .stop    (tmr_stop),
    .step    (tmr_step),
    .thresh  (cfg_timer_thresh),
    .running (tmr_running),
    .expire  (tmr_exp)
  );

  // release has priority over acknowledge
  always_comb begin
    pend_n = pend_q;
    if (sw_ack) pend_n = 1'b0;
    if (fire_c) pend_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      irq_q  <= pend_n & irq_unmask;
    end
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/rxc_checker.sv
module rxc_checker #(
  parameter int unsigned FCNT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              frm_valid,
  input logic              frm_irq_flag,
  input logic              cfg_enable,
  input logic [FCNT_W-1:0] cfg_frame_thresh,
  input logic              irq_unmask,
  input logic              sw_ack,
  input logic              irq_out,
  input logic              pend_q,
  input logic              fire_c,
  input logic              tmr_running,
  input logic              tmr_exp,
  input logic [FCNT_W-1:0] cnt_q
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!irq_out && !pend_q && !tmr_running));

  a_r2_direct_raise: assert property (@(posedge clk) disable iff (rst)
    (!cfg_enable && frm_valid && frm_irq_flag) |=> pend_q);

  a_r3_unflagged_no_arm: assert property (@(posedge clk) disable iff (rst)
    (!tmr_running && !(frm_valid && frm_irq_flag)) |=> !tmr_running);

  a_r4_count_bound: assert property (@(posedge clk) disable iff (rst || !cfg_enable)
    cnt_q < cfg_frame_thresh);

  a_r5_expiry_raises: assert property (@(posedge clk) disable iff (rst)
    tmr_exp |=> pend_q);

  a_r6_idle_after_release: assert property (@(posedge clk) disable iff (rst)
    fire_c |=> !tmr_running);

  a_r9_pending_holds: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !sw_ack) |=> pend_q);

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (sw_ack && !fire_c) |=> !pend_q);

  a_r11_mask_gates: assert property (@(posedge clk) disable iff (rst)
    !irq_unmask |=> !irq_out);
endmodule

bind rx_irq_coalescer rxc_checker #(.FCNT_W(FCNT_W)) chk_i (
  .clk              (clk),
  .rst              (rst),
  .frm_valid        (frm_valid),
  .frm_irq_flag     (frm_irq_flag),
  .cfg_enable       (cfg_enable),
  .cfg_frame_thresh (cfg_frame_thresh),
  .irq_unmask       (irq_unmask),
  .sw_ack           (sw_ack),
  .irq_out          (irq_out),
  .pend_q           (pend_q),
  .fire_c           (fire_c),
  .tmr_running      (tmr_running),
  .tmr_exp          (tmr_exp),
  .cnt_q            (cnt_q)
);

// File: tb/rx_irq_coalescer_tb_top.sv
module rx_irq_coalescer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ifc_clk = 1'b0;
  logic        frm_valid = 1'b0;
  logic        frm_irq_flag = 1'b0;
  logic        cfg_enable = 1'b0;
  logic        cfg_tmr_sel = 1'b1;
  logic [7:0]  cfg_frame_thresh = 8'd1;
  logic [15:0] cfg_timer_thresh = 16'd1;
  logic        irq_unmask = 1'b1;
  logic        sw_ack = 1'b0;
  logic        irq_out;

  always #10 clk = ~clk;

  rx_irq_coalescer dut_i (
    .clk              (clk),
    .rst              (rst),
    .ifc_clk          (ifc_clk),
    .frm_valid        (frm_valid),
    .frm_irq_flag     (frm_irq_flag),
    .cfg_enable       (cfg_enable),
    .cfg_tmr_sel      (cfg_tmr_sel),
    .cfg_frame_thresh (cfg_frame_thresh),
    .cfg_timer_thresh (cfg_timer_thresh),
    .irq_unmask       (irq_unmask),
    .sw_ack           (sw_ack),
    .irq_out          (irq_out)
  );

  int    cyc = 0;
  int    n_vec = 0;
  int    n_bad = 0;
  int    exp_q[$];
  string tag_q[$];
  bit    win_mode = 1'b0;
  int    win_rise = -1;
  logic  prev_irq = 1'b0;
  bit    finished = 1'b0;
  bit    if_run = 1'b0;
  int    if_div = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // slow interface clock: one toggle per two system cycles
  always @(negedge clk) begin
    if (if_run) begin
      if_div = if_div + 1;
      if (if_div == 2) begin
        if_div = 0;
        ifc_clk = ~ifc_clk;
      end
    end
  end

  // monitor: pop expected rise edges and compare
  always @(negedge clk) begin
    int    e;
    string t;
    if (rst) begin
      prev_irq = 1'b0;
    end else begin
      if (irq_out && !prev_irq) begin
        if (win_mode) begin
          win_rise = cyc;
        end else if (exp_q.size() == 0) begin
          n_vec++;
          n_bad++;
          $display("FAIL R3/R6/R8: unexpected interrupt rise, actual edge %0d expected none", cyc);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          n_vec++;
          if (e != cyc) begin
            n_bad++;
            $display("FAIL %s: interrupt rise actual edge %0d expected %0d", t, cyc, e);
          end
        end
      end
      prev_irq = irq_out;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input bit flag, output int edge_o);
    frm_valid    = 1'b1;
    frm_irq_flag = flag;
    edge_o       = cyc + 1;
    @(negedge clk);
    frm_valid    = 1'b0;
    frm_irq_flag = 1'b0;
  endtask

  task automatic ack();
    sw_ack = 1'b1;
    @(negedge clk);
    sw_ack = 1'b0;
  endtask

  task automatic expect_at(input int e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic chk(input string t, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: irq_out actual %0b expected %0b", t, act, exp);
    end
  endtask

  task automatic chk_range(input string t, input int act, input int lo, input int hi);
    n_vec++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: value actual %0d expected %0d..%0d", t, act, lo, hi);
    end
  endtask

  task automatic setcfg(input bit en, input bit sel, input int ft, input int tt);
    cfg_enable = 1'b0;
    @(negedge clk);
    cfg_tmr_sel      = sel;
    cfg_frame_thresh = 8'(ft);
    cfg_timer_thresh = 16'(tt);
    cfg_enable       = en;
    @(negedge clk);
  endtask

  initial begin
    int a;
    int e;
    int x;
    int s;
    idle(4);
    chk("R1 during reset", irq_out, 1'b0);
    rst = 1'b0;
    idle(2);
    chk("R1 after reset", irq_out, 1'b0);

    // R2: direct mode
    frame(1'b1, e);
    expect_at(e, "R2");
    idle(2);
    chk("R2 raised", irq_out, 1'b1);
    idle(5);
    chk("R9 held without ack", irq_out, 1'b1);
    ack();
    chk("R9 ack clears", irq_out, 1'b0);

    // R9: release in same cycle as ack wins
    frame(1'b1, e);
    expect_at(e, "R9 first");
    idle(2);
    sw_ack = 1'b1;
    frm_valid = 1'b1;
    frm_irq_flag = 1'b1;
    @(negedge clk);
    sw_ack = 1'b0;
    frm_valid = 1'b0;
    frm_irq_flag = 1'b0;
    idle(1);
    chk("R9 release beats ack", irq_out, 1'b1);
    ack();
    chk("R9 cleared", irq_out, 1'b0);

    // R3: unflagged frame in direct mode
    frame(1'b0, e);
    idle(3);
    chk("R3 unflagged direct", irq_out, 1'b0);

    // R4: threshold of 3 frames, long timer
    setcfg(1'b1, 1'b1, 3, 100);
    frame(1'b1, e);
    idle(1);
    frame(1'b1, e);
    idle(1);
    frame(1'b1, e);
    expect_at(e, "R4");
    idle(2);
    chk("R4 raised on third frame", irq_out, 1'b1);
    ack();
    idle(6500);
    chk("R6 timer idle after release", irq_out, 1'b0);

    // R5: timer release
    setcfg(1'b1, 1'b1, 10, 2);
    frame(1'b1, a);
    expect_at(a + 128, "R5");
    idle(200);
    ack();

    // R6: later frame does not restart the timer
    frame(1'b1, a);
    expect_at(a + 128, "R6");
    idle(49);
    frame(1'b1, x);
    idle(200);
    ack();

    // R3: unflagged frame in coalescing mode neither counts nor arms
    frame(1'b0, e);
    idle(300);
    chk("R3 unflagged coalesced", irq_out, 1'b0);

    // R8: threshold and expiry on the same edge
    setcfg(1'b1, 1'b1, 2, 1);
    frame(1'b1, a);
    expect_at(a + 64, "R8");
    idle(63);
    frame(1'b1, x);
    idle(150);
    ack();
    chk("R8 single interrupt then cleared", irq_out, 1'b0);

    // R10: counting continues while pending
    setcfg(1'b1, 1'b1, 2, 200);
    frame(1'b1, x);
    frame(1'b1, e);
    expect_at(e, "R10 first batch");
    idle(2);
    frame(1'b1, x);
    ack();
    chk("R10 ack cleared", irq_out, 1'b0);
    frame(1'b1, e);
    expect_at(e, "R10 counted while pending");
    idle(2);
    ack();

    // R11: mask holds pending state back
    setcfg(1'b1, 1'b1, 1, 5);
    irq_unmask = 1'b0;
    frame(1'b1, e);
    idle(3);
    chk("R11 masked", irq_out, 1'b0);
    irq_unmask = 1'b1;
    expect_at(cyc + 1, "R11 unmask");
    idle(2);
    chk("R11 pending shown after unmask", irq_out, 1'b1);
    ack();

    // R7: interface clock source
    setcfg(1'b1, 1'b0, 10, 1);
    frame(1'b1, a);
    idle(300);
    chk("R7 system clock ignored", irq_out, 1'b0);
    win_mode = 1'b1;
    win_rise = -1;
    s = cyc;
    if_run = 1'b1;
    idle(320);
    chk_range("R7 interface edge timing", win_rise, s + 250, s + 270);
    if_run = 1'b0;
    ack();
    idle(2);
    win_mode = 1'b0;

    idle(10);
    n_vec++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R4/R5: missing interrupts, actual %0d pending expected 0", exp_q.size());
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule